// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This block sits between a host and the command bus of a four-bank SDRAM device. Each cycle the host presents one request: no-op, activate, read, write, precharge or mode load. The block checks the request against the state of the bank it targets. That state is one of idle, opening, active with an open row, or closing. A legal request is put on the registered command bus with the bank select and the address bits in the device layout. An illegal request is replaced by a no-op and raises an error pulse.

For every bank the block records which row is open. When a request arrives at an active bank and carries that same row, the block marks it as a row hit. A mode word, which may be loaded only while every bank is idle, sets four values: the burst length, the read latency, and how long a bank stays in each transitional state. Opening a row also refreshes that row inside the device, so the host can treat each activate as a refresh of that row.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After a synchronous active-low reset, every bank is idle and the bus shows a no-op with the error and hit flags low. The configuration is burst length 1, read latency 2, activate field 1 and precharge field 1.
- R2: Request codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 mode load. An activate to an idle bank is issued on the next cycle with the bank select, and the 13-bit row is placed on address bits 0..12. The bank then enters the opening state (bank state encoding: 0 idle, 1 opening, 2 active, 3 closing; bank n occupies bank_state_o[2n+1:2n]).
- R3: A bank stays in the opening state for (activate field + 1) cycles and then becomes active.
- R4: A read or write to an active bank is issued. Column bits 0..9 go to address bits 0..9, column bit 10 goes to address bit 11, and address bits 10 and 12 are driven low.
- R5: A read or write to a bank that is not active produces a no-op on the bus and an error pulse.
- R6: An activate to a bank that is not idle produces a no-op and an error pulse, and the bank keeps its open row.
- R7: A precharge to an active bank is issued with all address bits low. The bank then closes for (precharge field + 1) cycles and returns to idle.
- R8: A precharge to an idle bank is issued without error and leaves the bank idle.
- R9: A precharge to a bank in the opening or closing state produces a no-op and an error pulse.
- R10: The row-hit output is high with a request exactly when the target bank is active and the request's row equals that bank's open row.
- R11: A mode load while every bank is idle is issued with the word on the address bus, and the configuration is updated. Word bits [1:0] give the burst code (length 1, 2, 4, 8), bits [5:3] the read latency, bits [8:6] the activate field and bits [11:9] the precharge field.
- R12: A mode load while any bank is not idle produces a no-op and an error pulse, and the configuration stays unchanged.
- R13: A request to one bank never changes the state or open row of another bank. Codes 6 and 7 act as a no-op without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cmd_i | input | 3 | Request code |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | 13 | Row, or mode word for a mode load |
| req_col_i | input | 11 | Column |
| bus_cmd_o | output | 3 | Issued command code (0 when nothing is issued) |
| bus_ba_o | output | 2 | Issued bank select |
| bus_addr_o | output | 13 | Issued address bits |
| err_o | output | 1 | One-cycle pulse for a rejected request |
| row_hit_o | output | 1 | Request targeted the open row of an active bank |
| bank_state_o | output | 8 | Two-bit state of each bank |
| cfg_burst_len_o | output | 4 | Decoded burst length |
| cfg_read_lat_o | output | 3 | Read latency |

## Verification
The bus fields, the error pulse and the hit flag are registered once, so each appears one clock edge after its request. The bench drives inputs on the falling edge and samples just after the following rising edge. A bank's state changes at the same edge that issues its command. Following the timing rule, a request made k cycles after an activate sees the opening state for k up to the activate field plus one. The table is ordered so that each request lands in the intended state. The directed tests count opening and closing samples one cycle at a time and compare the totals with the field values plus one.

// File: rtl/sdram_trk_pkg.sv
// Package: shared request codes and bank state encoding for the tracker.
// Assumes: request codes 6 and 7 are unused and treated as no-op.
package sdram_trk_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_MRS = 3'd5
    } req_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPENING = 2'd1,
        BK_ACTIVE  = 2'd2,
        BK_CLOSING = 2'd3
    } bank_st_e;
endpackage

// File: rtl/trk_mode_reg.sv
// Mode register: holds burst code, read latency and the two transition
// lengths. Loaded only when the top has accepted a mode load.
// Assumes: word bits [1:0] burst code, [5:3] latency, [8:6] activate
// field, [11:9] precharge field; bit 2 and bit 12 are ignored.
module trk_mode_reg #(
    parameter int ADDR_W = 13,
    parameter int TMR_W  = 3,
    parameter int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] word_i,
    output logic [3:0]        burst_len_o,
    output logic [LAT_W-1:0]  read_lat_o,
    output logic [TMR_W-1:0]  act_cyc_o,
    output logic [TMR_W-1:0]  pre_cyc_o
);
    localparam int LAT_LSB = 3;
    localparam int ACT_LSB = LAT_LSB + LAT_W;
    localparam int PRE_LSB = ACT_LSB + TMR_W;

    logic [1:0]       burst_code_q;
    logic [LAT_W-1:0] lat_q;
    logic [TMR_W-1:0] act_q;
    logic [TMR_W-1:0] pre_q;

    // Load the mode fields on an accepted mode load; reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_code_q <= 2'd0;
            lat_q        <= LAT_W'(2);
            act_q        <= TMR_W'(1);
            pre_q        <= TMR_W'(1);
        end else if (ld_i) begin
            burst_code_q <= word_i[1:0];
            lat_q        <= word_i[LAT_LSB +: LAT_W];
            act_q        <= word_i[ACT_LSB +: TMR_W];
            pre_q        <= word_i[PRE_LSB +: TMR_W];
        end
    end

    // Decode the burst code into a length.
    always_comb begin
        burst_len_o = 4'd1 << burst_code_q;
    end

    assign read_lat_o = lat_q;
    assign act_cyc_o  = act_q;
    assign pre_cyc_o  = pre_q;

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> ($stable(burst_code_q) && $stable(lat_q) && $stable(act_q) && $stable(pre_q)));
endmodule

// File: rtl/trk_bank_fsm.sv
// One bank's state machine: idle, opening, active, closing, with a
// down-counter for each transitional state and a record of the open row.
// Assumes: act_go only arrives in idle and pre_go only in active; the
// top checks legality before raising either.
module trk_bank_fsm #(
    parameter int ROW_W = 13,
    parameter int TMR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    act_go_i,
    input  logic                    pre_go_i,
    input  logic [TMR_W-1:0]        act_cyc_i,
    input  logic [TMR_W-1:0]        pre_cyc_i,
    input  logic [ROW_W-1:0]        row_i,
    output sdram_trk_pkg::bank_st_e state_o,
    output logic [ROW_W-1:0]        open_row_o
);
    import sdram_trk_pkg::*;

    bank_st_e         st_q;
    logic [TMR_W-1:0] cnt_q;
    logic [ROW_W-1:0] row_q;

    // Advance the bank state and its transition counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                BK_IDLE: if (act_go_i) begin
                    st_q  <= BK_OPENING;
                    cnt_q <= act_cyc_i;
                end
                BK_OPENING: if (cnt_q == '0) st_q <= BK_ACTIVE;
                            else cnt_q <= cnt_q - 1'b1;
                BK_ACTIVE: if (pre_go_i) begin
                    st_q  <= BK_CLOSING;
                    cnt_q <= pre_cyc_i;
                end
                BK_CLOSING: if (cnt_q == '0) st_q <= BK_IDLE;
                            else cnt_q <= cnt_q - 1'b1;
                default: st_q <= BK_IDLE;
            endcase
        end
    end

    // Capture the row being opened.
    always_ff @(posedge clk) begin
        if (!rst_n)        row_q <= '0;
        else if (act_go_i) row_q <= row_i;
    end

    assign state_o    = st_q;
    assign open_row_o = row_q;

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_go_i |=> (st_q == BK_OPENING));
    // R13
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_ACTIVE && !pre_go_i) |=> (st_q == BK_ACTIVE && $stable(row_q)));
    // R7
    close_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_CLOSING) |=> (st_q == BK_CLOSING || st_q == BK_IDLE));
    // R6
    no_act_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_go_i |-> (st_q == BK_IDLE));
endmodule

// File: rtl/trk_cmd_fmt.sv
// Command formatter: places bank, row, column or mode word on the device
// address bits for an issued request, and drives a no-op otherwise.
// Assumes: column bits at or above SKIP_BIT move up by one so that address
// bit SKIP_BIT stays low on reads and writes.
module trk_cmd_fmt #(
    parameter int ADDR_W   = 13,
    parameter int ROW_W    = 13,
    parameter int COL_W    = 11,
    parameter int BA_W     = 2,
    parameter int SKIP_BIT = 10
) (
    input  logic              issue_i,
    input  logic [2:0]        cmd_i,
    input  logic [BA_W-1:0]   bank_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    import sdram_trk_pkg::*;

    logic [ADDR_W-1:0] col_addr;

    // Spread the column across the address bits, stepping over SKIP_BIT.
    generate
        for (genvar j = 0; j < COL_W; j++) begin : g_col
            localparam int DST = (j < SKIP_BIT) ? j : j + 1;
            assign col_addr[DST] = col_i[j];
        end
        for (genvar k = 0; k < ADDR_W; k++) begin : g_pad
            if (k == SKIP_BIT || k > COL_W) begin : g_zero
                assign col_addr[k] = 1'b0;
            end
        end
    endgenerate

    // Select the address content for the issued request.
    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        if (issue_i) begin
            cmd_o = cmd_i;
            unique case (cmd_i)
                CMD_ACT: begin
                    ba_o   = bank_i;
                    addr_o = ADDR_W'(row_i);
                end
                CMD_RD, CMD_WR: begin
                    ba_o   = bank_i;
                    addr_o = col_addr;
                end
                CMD_PRE: ba_o = bank_i;
                CMD_MRS: addr_o = ADDR_W'(row_i);
                default: cmd_o = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_tracker.sv
// Top: checks each host request against the target bank's state, issues
// legal ones on a registered command bus, and rejects the rest with an
// error pulse. Tracks the open row per bank and flags row hits.
// Assumes: one request per cycle; outputs are registered once.
module sdram_bank_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 11,
    parameter int ADDR_W    = 13,
    parameter int TMR_W     = 3,
    parameter int LAT_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             req_cmd_i,
    input  logic [1:0]             req_bank_i,
    input  logic [ROW_W-1:0]       req_row_i,
    input  logic [COL_W-1:0]       req_col_i,
    output logic [2:0]             bus_cmd_o,
    output logic [1:0]             bus_ba_o,
    output logic [ADDR_W-1:0]      bus_addr_o,
    output logic                   err_o,
    output logic                   row_hit_o,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic [3:0]             cfg_burst_len_o,
    output logic [LAT_W-1:0]       cfg_read_lat_o
);
    import sdram_trk_pkg::*;

    localparam int BA_W = $clog2(NUM_BANKS);

    bank_st_e         st   [NUM_BANKS];
    logic [ROW_W-1:0] orow [NUM_BANKS];
    logic [NUM_BANKS-1:0] act_go, pre_go, idle_vec;
    logic [TMR_W-1:0] act_cyc, pre_cyc;
    logic [BA_W-1:0]  bank;
    bank_st_e         sel_st;
    logic [ROW_W-1:0] sel_row;
    logic             all_idle, known, legal, issue, hit_n, mode_ld;
    logic [2:0]       f_cmd;
    logic [1:0]       f_ba;
    logic [ADDR_W-1:0] f_addr;

    assign bank = BA_W'(req_bank_i);

    trk_mode_reg #(.ADDR_W(ADDR_W), .TMR_W(TMR_W), .LAT_W(LAT_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .ld_i(mode_ld), .word_i(ADDR_W'(req_row_i)),
        .burst_len_o(cfg_burst_len_o), .read_lat_o(cfg_read_lat_o),
        .act_cyc_o(act_cyc), .pre_cyc_o(pre_cyc)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            trk_bank_fsm #(.ROW_W(ROW_W), .TMR_W(TMR_W)) u_fsm (
                .clk(clk), .rst_n(rst_n),
                .act_go_i(act_go[b]), .pre_go_i(pre_go[b]),
                .act_cyc_i(act_cyc), .pre_cyc_i(pre_cyc),
                .row_i(req_row_i), .state_o(st[b]), .open_row_o(orow[b])
            );
            assign idle_vec[b] = (st[b] == BK_IDLE);
            assign bank_state_o[2*b +: 2] = st[b];
            assign act_go[b] = issue && (req_cmd_i == CMD_ACT) && (bank == BA_W'(b));
            assign pre_go[b] = issue && (req_cmd_i == CMD_PRE) && (bank == BA_W'(b))
                               && (st[b] == BK_ACTIVE);
        end
    endgenerate

    assign all_idle = &idle_vec;
    assign sel_st   = st[bank];
    assign sel_row  = orow[bank];

    // Decide whether the request is legal in its bank's current state.
    always_comb begin
        known = 1'b1;
        legal = 1'b0;
        unique case (req_cmd_i)
            CMD_ACT:        legal = (sel_st == BK_IDLE);
            CMD_RD, CMD_WR: legal = (sel_st == BK_ACTIVE);
            CMD_PRE:        legal = (sel_st == BK_IDLE) || (sel_st == BK_ACTIVE);
            CMD_MRS:        legal = all_idle;
            default:        known = 1'b0;
        endcase
    end

    assign issue   = known && legal;
    assign mode_ld = issue && (req_cmd_i == CMD_MRS);

    // Row hit: a bank request to an active bank whose open row matches.
    always_comb begin
        hit_n = known && (req_cmd_i != CMD_MRS) && (sel_st == BK_ACTIVE)
                && (sel_row == req_row_i);
    end

    trk_cmd_fmt #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(2),
                  .SKIP_BIT(10)) u_fmt (
        .issue_i(issue), .cmd_i(req_cmd_i), .bank_i(req_bank_i),
        .row_i(req_row_i), .col_i(req_col_i),
        .cmd_o(f_cmd), .ba_o(f_ba), .addr_o(f_addr)
    );

    // Register the bus fields and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_cmd_o  <= CMD_NOP;
            bus_ba_o   <= '0;
            bus_addr_o <= '0;
            err_o      <= 1'b0;
            row_hit_o  <= 1'b0;
        end else begin
            bus_cmd_o  <= f_cmd;
            bus_ba_o   <= f_ba;
            bus_addr_o <= f_addr;
            err_o      <= known && !legal;
            row_hit_o  <= hit_n;
        end
    end

    // R5
    rw_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_cmd_i == CMD_RD || req_cmd_i == CMD_WR) && sel_st != BK_ACTIVE)
        |=> (err_o && bus_cmd_o == CMD_NOP));
    // R9
    pre_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd_i == CMD_PRE && (sel_st == BK_OPENING || sel_st == BK_CLOSING))
        |=> (err_o && bus_cmd_o == CMD_NOP));
    // R4
    col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == CMD_RD || bus_cmd_o == CMD_WR) |-> (!bus_addr_o[10] && !bus_addr_o[12]));
    // R12
    mrs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd_i == CMD_MRS && !all_idle) |=> err_o);
    // R10
    hit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_hit_o |-> !err_o || $past(req_cmd_i) == CMD_ACT);
endmodule

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  req_cmd;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [10:0] req_col;
    logic [2:0]  bus_cmd;
    logic [1:0]  bus_ba;
    logic [12:0] bus_addr;
    logic        err, hit;
    logic [7:0]  bst;
    logic [3:0]  blen;
    logic [2:0]  rlat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdram_bank_tracker dut (
        .clk(clk), .rst_n(rst_n), .req_cmd_i(req_cmd), .req_bank_i(req_bank),
        .req_row_i(req_row), .req_col_i(req_col), .bus_cmd_o(bus_cmd),
        .bus_ba_o(bus_ba), .bus_addr_o(bus_addr), .err_o(err), .row_hit_o(hit),
        .bank_state_o(bst), .cfg_burst_len_o(blen), .cfg_read_lat_o(rlat)
    );

    // fields: cmd bank row col | exp_cmd exp_ba exp_addr exp_err exp_hit
    localparam logic [48:0] VEC [14] = '{
        {3'd1, 2'd0, 13'h0155, 11'h000, 3'd1, 2'd0, 13'h0155, 1'b0, 1'b0},
        {3'd2, 2'd0, 13'h0155, 11'h005, 3'd0, 2'd0, 13'h0000, 1'b1, 1'b0},
        {3'd4, 2'd0, 13'h0000, 11'h000, 3'd0, 2'd0, 13'h0000, 1'b1, 1'b0},
        {3'd2, 2'd0, 13'h0155, 11'h7FF, 3'd2, 2'd0, 13'h0BFF, 1'b0, 1'b1},
        {3'd3, 2'd0, 13'h00AA, 11'h400, 3'd3, 2'd0, 13'h0800, 1'b0, 1'b0},
        {3'd1, 2'd0, 13'h0001, 11'h000, 3'd0, 2'd0, 13'h0000, 1'b1, 1'b0},
        {3'd4, 2'd1, 13'h0000, 11'h000, 3'd4, 2'd1, 13'h0000, 1'b0, 1'b0},
        {3'd1, 2'd2, 13'h1FFF, 11'h000, 3'd1, 2'd2, 13'h1FFF, 1'b0, 1'b0},
        {3'd3, 2'd0, 13'h0155, 11'h123, 3'd3, 2'd0, 13'h0123, 1'b0, 1'b1},
        {3'd4, 2'd0, 13'h0000, 11'h000, 3'd4, 2'd0, 13'h0000, 1'b0, 1'b0},
        {3'd2, 2'd0, 13'h0155, 11'h000, 3'd0, 2'd0, 13'h0000, 1'b1, 1'b0},
        {3'd5, 2'd0, 13'h00DB, 11'h000, 3'd0, 2'd0, 13'h0000, 1'b1, 1'b0},
        {3'd2, 2'd2, 13'h1FFF, 11'h000, 3'd2, 2'd2, 13'h0000, 1'b0, 1'b1},
        {3'd1, 2'd0, 13'h0002, 11'h000, 3'd1, 2'd0, 13'h0002, 1'b0, 1'b0}
    };
    localparam string TAG [14] = '{"R2", "R5", "R9", "R4", "R4", "R6", "R8",
                                   "R2", "R13", "R7", "R5", "R12", "R10", "R2"};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request on the falling edge, sample after the next rising edge.
    task automatic step(input logic [2:0] c, input logic [1:0] b,
                        input logic [12:0] r, input logic [10:0] co);
        @(negedge clk);
        req_cmd = c; req_bank = b; req_row = r; req_col = co;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_cmd = 3'd0; req_bank = 2'd0; req_row = '0; req_col = '0;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst_n = 1'b0;
        req_cmd = 3'd0; req_bank = 2'd0; req_row = '0; req_col = '0;
        do_reset();
        // R1 reset state
        check("R1", bus_cmd, 0);
        check("R1", err, 0);
        check("R1", hit, 0);
        check("R1", bst, 0);
        check("R1", blen, 1);
        check("R1", rlat, 2);

        // table walk with default timing (both fields 1)
        for (int i = 0; i < 14; i++) begin
            logic [48:0] v;
            v = VEC[i];
            step(v[48:46], v[45:44], v[43:31], v[30:20]);
            check(TAG[i], bus_cmd, v[19:17]);
            check(TAG[i], bus_ba, v[16:15]);
            check(TAG[i], bus_addr, v[14:2]);
            check(TAG[i], err, v[1]);
            check(TAG[i], hit, v[0]);
        end
        // R12 rejected mode load left configuration alone
        check("R12", blen, 1);
        check("R12", rlat, 2);
        // R13 bank 2 still active, bank 1 idle
        check("R13", bst[5:4], 2);
        check("R13", bst[3:2], 0);

        // R11 mode load with all idle: burst 8, latency 3, act 3, pre 0
        do_reset();
        step(3'd5, 2'd0, 13'h00DB, 11'h000);
        check("R11", bus_cmd, 5);
        check("R11", bus_addr, 13'h00DB);
        check("R11", err, 0);
        check("R11", blen, 8);
        check("R11", rlat, 3);

        // R3 opening lasts activate field + 1 = 4 cycles
        step(3'd1, 2'd3, 13'h0007, 11'h000);
        cnt = 0;
        while (bst[7:6] == 2'd1 && cnt < 20) begin
            cnt++;
            step(3'd0, 2'd0, 13'h0000, 11'h000);
        end
        check("R3", cnt, 4);
        check("R3", bst[7:6], 2);
        // R13 other banks untouched
        check("R13", bst[5:0], 0);

        // R7 closing lasts precharge field + 1 = 1 cycle
        step(3'd4, 2'd3, 13'h0000, 11'h000);
        check("R7", bus_cmd, 4);
        cnt = 0;
        while (bst[7:6] == 2'd3 && cnt < 20) begin
            cnt++;
            step(3'd0, 2'd0, 13'h0000, 11'h000);
        end
        check("R7", cnt, 1);
        check("R7", bst[7:6], 0);

        // R8 precharge to idle bank: issued, no error, still idle
        step(3'd4, 2'd3, 13'h0000, 11'h000);
        check("R8", bus_cmd, 4);
        check("R8", err, 0);
        check("R8", bst[7:6], 0);

        // R13 unused code 6 acts as no-op without error
        step(3'd6, 2'd0, 13'h0000, 11'h000);
        check("R13", bus_cmd, 0);
        check("R13", err, 0);

        // R10 no hit on an idle bank even with matching stored row
        step(3'd2, 2'd3, 13'h0007, 11'h000);
        check("R10", hit, 0);
        check("R5", err, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule